// File: doc/BRIEF.md
# Nonvolatile Page-Write Sequencer

This block turns single-byte write requests from a bus front end into page-mode program cycles on a byte-wide nonvolatile array. The array is modelled as a register array. A host issues between one and a full page of byte writes in a row. Every accepted byte lands in a page buffer and re-arms an inactivity window. When the window runs out with no further byte, the buffered bytes are committed in one programming phase of fixed, parameterised length. The array cell physics are not modelled.

A write-lock input gates the whole path. While it is high no byte is taken. If it rises while a page is still collecting bytes, that page is thrown away. During programming the host can poll with ordinary reads: each read returns a status word whose flag bit flips on every poll. Once the phase ends, reads return stored data again. An optional interrupt flags each finished phase. There are two resets. The bus reset clears the control state but lets a running program phase finish. The power-on reset clears everything except the array contents.

Top module: `pgwr_seq`

## Requirements
- R1: A page holds 1 to 32 bytes. `addr[4:0]` picks the slot inside the page. The upper address bits come from the first byte of the page, and the upper bits of later bytes are ignored. Only the slots that were written change in the array.
- R2: `busy` rises exactly LOAD_CYC clock cycles after the edge that took the last byte. A byte taken on any of those LOAD_CYC edges, including the last one, re-arms the window and keeps the page open.
- R3: `busy` stays high for exactly PROG_CYC cycles. When it falls, the buffered bytes are in the array and reads return them.
- R4: A write request made while `wr_lock` is high is not accepted. No page opens and the array is unchanged.
- R5: If `wr_lock` is high on any cycle while a page is collecting bytes, the page is dropped. `busy` never rises for it and the array is unchanged.
- R6: Write requests made while `busy` is high are ignored. No new page opens afterwards and the array is unchanged.
- R7: A read (`rd_en`) updates `rdata` one cycle later, and `rdata` holds its value between reads. A read during `busy` returns a word with only bit 6 possibly set. Bit 6 is 0 on the first poll of a program phase and then alternates on each poll.
- R8: When a program phase ends with `irq_en` high, `irq` goes high in the same cycle that `busy` falls. `irq` stays high until the next read or a bus reset. `irq` never rises when `irq_en` is low.
- R9: A low `rst_n` drops a page that is collecting bytes, clears `irq` and clears `rdata`. It does not stop or shorten a program phase that is already running.
- R10: After a power-on reset, `busy`, `irq` and `rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears all control state |
| rst_n | input | 1 | Bus reset, synchronous, active low; spares a running program phase |
| wr_en | input | 1 | Byte write request |
| wr_lock | input | 1 | Write lock; high blocks writes and cancels a page that is collecting bytes |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Byte address for the read or write |
| wdata | input | DATA_W | Write data byte |
| irq_en | input | 1 | Enables the completion interrupt |
| rdata | output | DATA_W | Registered read data or polling status |
| busy | output | 1 | High while the program phase runs |
| irq | output | 1 | Completion interrupt, sticky |

## Verification
A collection window that expires at the wrong count shows up directly on `busy`: it rises one or more cycles early or late relative to the last byte, so the bench samples it on the two cycles around the expected edge. A corrupted slot mask or latched page shows up only after the phase completes, when a read returns a stale byte or an untouched neighbour has changed. Readback therefore covers every known byte of the page. A stuck or mis-cleared poll flag appears on the second poll of a phase. A reset that wrongly reaches the program engine shows as `busy` falling during or right after the reset pulse.

// File: rtl/pgwr_pkg.sv
// Shared types for the page-write sequencer.
package pgwr_pkg;

    // Sequencer phase: waiting, collecting page bytes, programming the array.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } seq_st_t;

endpackage

// File: rtl/pgwr_dcnt.sv
// Loadable down counter with a zero flag.
// Assumes: ld has priority over dec; the count holds at zero.
module pgwr_dcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: reset, reload, or step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ld)
            cnt_q <= ld_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pgwr_page_buf.sv
// Page buffer: one data register and one valid bit per slot.
// Assumes: clr and wr never refer to the same cycle's data (clr wins).
module pgwr_page_buf #(
    parameter int SLOT_W = 5,
    parameter int DATA_W = 8,
    localparam int SLOTS = 1 << SLOT_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         wr,
    input  logic [SLOT_W-1:0]            wr_slot,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [SLOTS-1:0][DATA_W-1:0] buf_data,
    output logic [SLOTS-1:0]             buf_vld
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic hit;
        assign hit = wr && (wr_slot == SLOT_W'(g));

        // Slot valid bit: set by a write, cleared by a drop or commit.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                buf_vld[g] <= 1'b0;
            else if (hit)
                buf_vld[g] <= 1'b1;
        end

        // Slot data: the last byte written to this slot wins.
        always_ff @(posedge clk) begin
            if (hit)
                buf_data[g] <= wr_data;
        end
    end

endmodule

// File: rtl/pgwr_array.sv
// Byte array that models the nonvolatile store, with a whole-page commit port.
// Assumes: contents survive every reset; one asynchronous read port.
module pgwr_array #(
    parameter int ADDR_W = 8,
    parameter int SLOT_W = 5,
    parameter int DATA_W = 8,
    localparam int SLOTS  = 1 << SLOT_W,
    localparam int PAGE_W = ADDR_W - SLOT_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                         clk,
    input  logic                         commit,
    input  logic [PAGE_W-1:0]            page,
    input  logic [SLOTS-1:0][DATA_W-1:0] pg_data,
    input  logic [SLOTS-1:0]             pg_vld,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit: program every valid slot of the buffered page at once.
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (pg_vld[i])
                    mem[{page, SLOT_W'(i)}] <= pg_data[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pgwr_seq.sv
// Page-write sequencer top. It collects byte writes into a page buffer, closes
// the page after LOAD_CYC idle cycles, programs for PROG_CYC cycles, and answers
// polls with a toggling flag while it programs.
// Assumes: por_n is applied once at power-up; rst_n may pulse at any time.
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int SLOT_W   = 5,
    parameter int LOAD_CYC = 12500,
    parameter int PROG_CYC = 625000,
    parameter int TOG_BIT  = 6
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_lock,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              irq
);

    localparam int SLOTS   = 1 << SLOT_W;
    localparam int PAGE_W  = ADDR_W - SLOT_W;
    localparam int MAX_CYC = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_st_t                      st_q;
    logic [PAGE_W-1:0]            page_q;
    logic                         tog_q;
    logic                         accept, drop, close, commit;
    logic                         win_zero, prog_zero;
    logic [SLOTS-1:0][DATA_W-1:0] pg_data;
    logic [SLOTS-1:0]             pg_vld;
    logic [DATA_W-1:0]            arr_rd;
    logic [DATA_W-1:0]            poll_word;

    // Request decode: take a byte only when unlocked, idle or loading, bus out of reset.
    assign accept = wr_en && !wr_lock && rst_n && (st_q != ST_PROG);
    assign drop   = (st_q == ST_LOAD) && (!rst_n || wr_lock);
    assign close  = (st_q == ST_LOAD) && !drop && !accept && win_zero;
    assign commit = (st_q == ST_PROG) && prog_zero;
    assign busy   = (st_q == ST_PROG);

    // Phase register: only power-on reset may abort a running program phase.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (accept) st_q <= ST_LOAD;
                ST_LOAD: begin
                    if (drop)       st_q <= ST_IDLE;
                    else if (close) st_q <= ST_PROG;
                end
                ST_PROG: if (prog_zero) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Page address: taken from the first byte of each page.
    always_ff @(posedge clk) begin
        if (!por_n)
            page_q <= '0;
        else if (accept && st_q == ST_IDLE)
            page_q <= addr[ADDR_W-1:SLOT_W];
    end

    // Inactivity window: re-armed on each accepted byte.
    pgwr_dcnt #(.CNT_W(CNT_W)) u_win (
        .clk    (clk),
        .rst_n  (por_n),
        .ld     (accept),
        .ld_val (CNT_W'(LOAD_CYC - 1)),
        .dec    (st_q == ST_LOAD),
        .zero   (win_zero)
    );

    // Program-phase timer: loaded when the page closes.
    pgwr_dcnt #(.CNT_W(CNT_W)) u_prog (
        .clk    (clk),
        .rst_n  (por_n),
        .ld     (close),
        .ld_val (CNT_W'(PROG_CYC - 1)),
        .dec    (st_q == ST_PROG),
        .zero   (prog_zero)
    );

    pgwr_page_buf #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (por_n),
        .clr      (drop || commit),
        .wr       (accept),
        .wr_slot  (addr[SLOT_W-1:0]),
        .wr_data  (wdata),
        .buf_data (pg_data),
        .buf_vld  (pg_vld)
    );

    pgwr_array #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .commit  (commit),
        .page    (page_q),
        .pg_data (pg_data),
        .pg_vld  (pg_vld),
        .rd_addr (addr),
        .rd_data (arr_rd)
    );

    // Poll flag: restarts at 0 each phase and flips on every busy read.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n || !busy)
            tog_q <= 1'b0;
        else if (rd_en)
            tog_q <= !tog_q;
    end

    always_comb begin
        poll_word          = '0;
        poll_word[TOG_BIT] = tog_q;
    end

    // Read data register: status word while busy, array contents otherwise.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= busy ? poll_word : arr_rd;
    end

    // Completion interrupt: set when a phase ends, cleared by a read or reset.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n)
            irq <= 1'b0;
        else if (commit && irq_en)
            irq <= 1'b1;
        else if (rd_en)
            irq <= 1'b0;
    end

endmodule

// File: rtl/pgwr_seq_chk.sv
// Assertion checker for pgwr_seq, attached with bind.
// Assumes: it sees only the top-level ports.
module pgwr_seq_chk #(
    parameter int DATA_W   = 8,
    parameter int PROG_CYC = 625000,
    parameter int TOG_BIT  = 6
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_lock,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic              busy,
    input logic              irq
);

    localparam logic [DATA_W-1:0] NON_TOG = ~(DATA_W'(1) << TOG_BIT);

    int unsigned busy_run;

    // Busy run length: counts consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!por_n || !busy)
            busy_run <= 0;
        else
            busy_run <= busy_run + 1;
    end

    // R3: every program phase lasts exactly PROG_CYC cycles.
    p_busy_len_r3: assert property (@(posedge clk) disable iff (!por_n)
        $fell(busy) |-> busy_run == PROG_CYC);

    // R2: programming starts only on an edge without an accepted byte.
    p_start_idle_r2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(busy) |-> $past(!wr_en && !wr_lock));

    // R5: a lock cycle outside programming keeps busy low on the next cycle.
    p_lock_no_prog_r5: assert property (@(posedge clk) disable iff (!por_n)
        (wr_lock && !busy) |=> !busy);

    // R7: a poll returns only the flag bit.
    p_poll_word_r7: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && busy && rst_n) |=> (rdata & NON_TOG) == '0);

    // R7: read data holds between reads.
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
        (!rd_en && rst_n) |=> $stable(rdata));

    // R8: the interrupt rises only as a phase ends.
    p_irq_at_end_r8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(irq) |-> $fell(busy));

    // R9: a bus reset outside programming cannot start a phase.
    p_rst_no_prog_r9: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && !busy) |=> !busy);

endmodule

bind pgwr_seq pgwr_seq_chk #(
    .DATA_W   (DATA_W),
    .PROG_CYC (PROG_CYC),
    .TOG_BIT  (TOG_BIT)
) u_chk (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_lock (wr_lock),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .busy    (busy),
    .irq     (irq)
);

// File: tb/pgwr_seq_tb.sv
// Self-checking bench for pgwr_seq: a table of page writes, then directed cases.
module pgwr_seq_tb;

    localparam int LCYC = 8;
    localparam int PCYC = 20;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_lock = 1'b0, rd_en = 1'b0, irq_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       busy, irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [7:0] mdl [256];
    logic       mvld [256];
    logic [7:0] pend_d [32];
    logic       pend_v [32];
    logic [2:0] pend_pg;
    logic       pend_open = 1'b0;

    always #4 clk = ~clk;

    pgwr_seq #(.LOAD_CYC(LCYC), .PROG_CYC(PCYC)) u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_lock(wr_lock),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .irq_en(irq_en),
        .rdata(rdata), .busy(busy), .irq(irq)
    );

    // Table entry: {first address[8], byte count[6], data seed[8], gap cycles[4]}.
    localparam logic [25:0] VEC [8] = '{
        {8'h00, 6'd32, 8'h11, 4'd0},
        {8'h20, 6'd32, 8'h52, 4'd0},
        {8'h40, 6'd32, 8'h93, 4'd1},
        {8'h60, 6'd32, 8'hC4, 4'd0},
        {8'h45, 6'd1,  8'h3A, 4'd0},
        {8'h63, 6'd5,  8'h70, 4'd7},
        {8'h2C, 6'd20, 8'hE1, 4'd3},
        {8'h9E, 6'd2,  8'h08, 4'd2}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wbyte(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        if (!wr_lock && !busy && rst_n) begin
            if (!pend_open) begin pend_open = 1'b1; pend_pg = a[7:5]; end
            pend_d[a[4:0]] = d; pend_v[a[4:0]] = 1'b1;
        end
    endtask

    task automatic rbyte(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic model_commit();
        for (int i = 0; i < 32; i++) begin
            if (pend_v[i]) begin mdl[{pend_pg, 5'(i)}] = pend_d[i]; mvld[{pend_pg, 5'(i)}] = 1'b1; end
            pend_v[i] = 1'b0;
        end
        pend_open = 1'b0;
    endtask

    task automatic model_drop();
        for (int i = 0; i < 32; i++) pend_v[i] = 1'b0;
        pend_open = 1'b0;
    endtask

    // Called right after the last byte: checks window expiry and phase length.
    task automatic wait_commit(input logic exp_irq);
        repeat (LCYC - 1) @(negedge clk);
        chk("R2 busy low before window end", 8'(busy), 8'h0);
        @(negedge clk);
        chk("R2 busy at window end", 8'(busy), 8'h1);
        repeat (PCYC - 1) @(negedge clk);
        chk("R3 busy before phase end", 8'(busy), 8'h1);
        @(negedge clk);
        chk("R3 busy after phase end", 8'(busy), 8'h0);
        chk("R8 irq at phase end", 8'(irq), 8'(exp_irq));
        model_commit();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * (LCYC + PCYC) && (busy || pend_open); i++) begin
            @(negedge clk);
            if (!busy && i > LCYC + 1) break;
        end
        model_commit();
    endtask

    task automatic check_page(input logic [2:0] pg, input string req);
        logic [7:0] d;
        for (int i = 0; i < 32; i++) begin
            if (mvld[{pg, 5'(i)}]) begin
                rbyte({pg, 5'(i)}, d);
                chk(req, d, mdl[{pg, 5'(i)}]);
            end
        end
    endtask

    task automatic quiet(input int n, input string req);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin @(negedge clk); seen |= busy; end
        chk(req, 8'(seen), 8'h0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 256; i++) mvld[i] = 1'b0;
        for (int i = 0; i < 32; i++) pend_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        // R10: power-on state
        chk("R10 busy", 8'(busy), 8'h0);
        chk("R10 irq", 8'(irq), 8'h0);
        chk("R10 rdata", rdata, 8'h00);

        // R1 R2 R3 R8: table of page writes
        for (int v = 0; v < 8; v++) begin
            logic [7:0] a0   = VEC[v][25:18];
            int         cnt  = int'(VEC[v][17:12]);
            logic [7:0] seed = VEC[v][11:4];
            int         gap  = int'(VEC[v][3:0]);
            irq_en = (v % 2 == 0);
            for (int i = 0; i < cnt; i++) begin
                wbyte(a0 + 8'(i), seed + 8'(i * 7));
                if (i != cnt - 1) repeat (gap) @(negedge clk);
            end
            wait_commit(v % 2 == 0);
            check_page(a0[7:5], "R1 page readback");
            chk("R8 irq cleared by read", 8'(irq), 8'h0);
        end

        // R1: later bytes keep the first byte's page
        irq_en = 1'b0;
        wbyte(8'h40, 8'hA5);
        wbyte(8'hA3, 8'h5A);
        wait_commit(1'b0);
        check_page(3'd2, "R1 upper bits of later byte ignored");
        rbyte(8'hA3, d);
        chk("R1 other page untouched", 8'(mvld[8'hA3]), 8'h0);

        // R7: polling during programming
        wbyte(8'h07, 8'hEE);
        repeat (LCYC) @(negedge clk);
        rbyte(8'h07, d); chk("R7 first poll", d, 8'h00);
        rbyte(8'h07, d); chk("R7 second poll", d, 8'h40);
        rbyte(8'h07, d); chk("R7 third poll", d, 8'h00);
        @(negedge clk);
        chk("R7 rdata holds", rdata, 8'h00);
        rbyte(8'h07, d); chk("R7 fourth poll", d, 8'h40);
        wait_idle();
        rbyte(8'h07, d); chk("R7 data after phase", d, 8'hEE);

        // R6: writes during programming ignored
        wbyte(8'h08, 8'h12);
        repeat (LCYC + 1) @(negedge clk);
        wbyte(8'h05, 8'hFF);
        wait_idle();
        quiet(LCYC + 3, "R6 no page after busy write");
        rbyte(8'h05, d); chk("R6 array unchanged", d, mdl[8'h05]);

        // R4: locked writes not accepted
        wr_lock = 1'b1;
        wbyte(8'h06, 8'h99);
        wr_lock = 1'b0;
        quiet(LCYC + PCYC, "R4 no phase under lock");
        rbyte(8'h06, d); chk("R4 array unchanged", d, mdl[8'h06]);

        // R5: lock during collection drops page
        wbyte(8'h09, 8'h77);
        repeat (LCYC - 2) @(negedge clk);
        wr_lock = 1'b1; @(negedge clk); wr_lock = 1'b0;
        model_drop();
        quiet(LCYC + PCYC, "R5 no phase after cancel");
        rbyte(8'h09, d); chk("R5 array unchanged", d, mdl[8'h09]);

        // R9: bus reset during collection drops page and clears rdata
        wbyte(8'h0A, 8'h66);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        model_drop();
        chk("R9 rdata cleared", rdata, 8'h00);
        quiet(LCYC + PCYC, "R9 no phase after reset");
        rbyte(8'h0A, d); chk("R9 array unchanged", d, mdl[8'h0A]);

        // R9: bus reset during programming does not stop it
        irq_en = 1'b1;
        wbyte(8'h0B, 8'h3C);
        repeat (LCYC) @(negedge clk);
        chk("R9 busy before reset", 8'(busy), 8'h1);
        rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
        chk("R9 busy through reset", 8'(busy), 8'h1);
        repeat (PCYC - 3) @(negedge clk);
        chk("R9 busy holds full length", 8'(busy), 8'h1);
        @(negedge clk);
        chk("R9 phase ends on time", 8'(busy), 8'h0);
        chk("R8 irq after reset phase", 8'(irq), 8'h1);
        model_commit();
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        chk("R9 irq cleared by reset", 8'(irq), 8'h0);
        rbyte(8'h0B, d); chk("R9 data committed", d, 8'h3C);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule